// File: doc/BRIEF.md
# I2C Transaction Event Aggregator

This block sits beside an I2C master's bus engine and turns that engine's one-cycle event strobes into a decision about whether the current transfer is over. There are four event strobes: transaction complete, address/data ACK error, high-speed NACK error and restart-transfer done. The strobes set bits in a status register that software clears by writing ones. A mask register chooses which status bits drive the interrupt line. Software reaches both registers through a small register port.

The block also keeps a second, sticky copy of the events for the transfer in progress. Each new transfer clears that copy with an explicit clear strobe. From the sticky copy the block raises a one-cycle done pulse and holds a separate error level. Because of this, an ACK error that comes one interrupt ahead of the completion event is still reported together with that completion.

For multi-message high-speed sequences, a sequence-start strobe can arm a swallow mode. When armed, the first restart event does not complete the transfer. Instead it wipes the sticky copy and sends a start command with the start, multi-trigger and multi-config bits set, so that the engine goes on with the real transfer.

Top module: `i2c_evt_agg`

## Requirements
- R1: After synchronous reset the status, mask and sticky registers are zero, and irq, done_pulse, err_flag, go_valid and go_cmd are all 0.
- R2: Each event strobe sets its own status bit: complete is bit 0, ACK error is bit 1, high-speed NACK is bit 2 and restart done is bit 4. All other status and mask bits always read 0. reg_sel 0 selects status and reg_sel 1 selects mask. reg_rdata shows the selected register's value after the clock edge on which reg_sel was sampled.
- R3: A register-port write to status clears every bit that has a 1 in reg_wdata and leaves every bit that has a 0 unchanged.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The mask register is written whole, using the same bit positions as status. irq is 1 in the cycle after an edge exactly when the status AND mask of that edge is non-zero.
- R6: An ACK error followed in a later cycle by a complete event gives a done pulse with err_flag at 1, because the sticky copy holds both events.
- R7: done_pulse is 1 for one cycle, on the first edge where the sticky copy holds complete, or holds restart done while cfg_auto_rs is 1. With cfg_auto_rs at 0, restart done alone never completes a transfer. After that pulse, further events give no more pulses until xfer_clear.
- R8: err_flag is 1 while the sticky copy holds an ACK error or a high-speed NACK.
- R9: seq_start arms swallow mode only if cfg_auto_rs is 1, cfg_msg_cnt is at least 2 and cfg_fast is 1. Otherwise it disarms swallow mode.
- R10: When swallow mode is armed and a restart event arrives, the block disarms, clears the sticky copy, gives no done pulse, and drives go_valid for one cycle with go_cmd = 0xC001 (bits 15, 14 and 0).
- R11: xfer_clear empties the sticky copy and the done-seen state but leaves the status register unchanged. Events that arrive in the same cycle as xfer_clear are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata | input | REG_W | Write data (ones clear bits when status is selected) |
| reg_rdata | output | REG_W | Value of the selected register |
| ev_comp | input | 1 | Transaction complete strobe |
| ev_ackerr | input | 1 | ACK error strobe |
| ev_hsnack | input | 1 | High-speed NACK strobe |
| ev_rsdone | input | 1 | Restart-transfer done strobe |
| xfer_clear | input | 1 | Start of a new transfer: clears the sticky copy |
| seq_start | input | 1 | Start of a message sequence: loads the swallow arm |
| cfg_auto_rs | input | 1 | Auto-restart enabled |
| cfg_msg_cnt | input | CNT_W | Number of messages queued |
| cfg_fast | input | 1 | Bus speed above 400 kHz |
| irq | output | 1 | Masked interrupt |
| done_pulse | output | 1 | One-cycle transfer-finished pulse |
| err_flag | output | 1 | Accumulated error level |
| go_valid | output | 1 | Re-issued start command valid |
| go_cmd | output | REG_W | Start command value |

## Verification
The assertions assume that the event strobes are synchronous to clk and that each one stays high for a single cycle per event. They also assume that cfg_auto_rs is held steady while a transfer is in flight, because the completion rule reads it live. The bench drives every input on the falling edge, pulses each strobe for exactly one cycle, and changes the configuration inputs only between transfers, before it issues seq_start or xfer_clear.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  // Status / mask bit positions (software decodes these)
  localparam int B_COMP   = 0;
  localparam int B_ACK    = 1;
  localparam int B_HSNACK = 2;
  localparam int B_RSDONE = 4;
  // Start command bit positions (the bus engine decodes these)
  localparam int B_GO     = 0;
  localparam int B_MTRIG  = 14;
  localparam int B_MCFG   = 15;
endpackage

// File: rtl/evt_status_regs.sv
module evt_status_regs
  import i2c_evt_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] ev_vec,
  input  logic             we,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata_q,
  output logic             irq_q
);
  localparam logic [REG_W-1:0] VALID =
    REG_W'((1 << B_COMP) | (1 << B_ACK) | (1 << B_HSNACK) | (1 << B_RSDONE));

  logic [REG_W-1:0] stat_q, stat_n;
  logic [REG_W-1:0] mask_q, mask_n;
  logic [REG_W-1:0] clr_vec;

  always_comb begin
    clr_vec = (we && !sel) ? wdata : '0;
    // events override a same-cycle clear
    stat_n  = ((stat_q & ~clr_vec) | ev_vec) & VALID;
    mask_n  = (we && sel) ? (wdata & VALID) : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      stat_q  <= stat_n;
      mask_q  <= mask_n;
      rdata_q <= sel ? mask_n : stat_n;
      irq_q   <= |(stat_n & mask_n);
    end
  end

  // R3
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !sel) |=> ((stat_q & $past(wdata) & ~$past(ev_vec)) == '0));
  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|ev_vec) |=> ((stat_q & $past(ev_vec)) == $past(ev_vec)));
  // R5
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|(stat_q & mask_q)));
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_q | mask_q) & ~VALID) == '0);
endmodule

// File: rtl/evt_tracker.sv
module evt_tracker
  import i2c_evt_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int CNT_W    = 8,
  parameter int MIN_MSGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] ev_vec,
  input  logic             xfer_clear,
  input  logic             seq_start,
  input  logic             cfg_auto_rs,
  input  logic [CNT_W-1:0] cfg_msg_cnt,
  input  logic             cfg_fast,
  output logic             done_q,
  output logic             err_q,
  output logic             go_v_q,
  output logic [REG_W-1:0] go_cmd_q
);
  localparam logic [REG_W-1:0] GO_WORD =
    REG_W'((1 << B_GO) | (1 << B_MTRIG) | (1 << B_MCFG));

  logic [REG_W-1:0] acc_q, acc_base, acc_n;
  logic             seen_q, seen_base;
  logic             armed_q, arm_cond, swallow, fin;

  always_comb begin
    acc_base  = xfer_clear ? '0 : acc_q;
    seen_base = xfer_clear ? 1'b0 : seen_q;
    acc_n     = acc_base | ev_vec;
    swallow   = armed_q && ev_vec[B_RSDONE];
    fin       = acc_n[B_COMP] || (acc_n[B_RSDONE] && cfg_auto_rs);
    arm_cond  = cfg_auto_rs && cfg_fast && (cfg_msg_cnt >= CNT_W'(MIN_MSGS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      seen_q   <= 1'b0;
      armed_q  <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      go_v_q   <= 1'b0;
      go_cmd_q <= '0;
    end else begin
      if (seq_start)    armed_q <= arm_cond;
      else if (swallow) armed_q <= 1'b0;

      if (swallow) begin
        acc_q    <= '0;
        seen_q   <= seen_base;
        done_q   <= 1'b0;
        err_q    <= 1'b0;
        go_v_q   <= 1'b1;
        go_cmd_q <= GO_WORD;
      end else begin
        acc_q    <= acc_n;
        seen_q   <= seen_base | fin;
        done_q   <= fin & ~seen_base;
        err_q    <= acc_n[B_ACK] | acc_n[B_HSNACK];
        go_v_q   <= 1'b0;
        go_cmd_q <= '0;
      end
    end
  end

  // R10
  no_done_on_go_chk: assert property (@(posedge clk) disable iff (rst)
    go_v_q |-> !done_q);
  // R10
  go_single_chk: assert property (@(posedge clk) disable iff (rst)
    go_v_q |=> !go_v_q);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R8
  err_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_clear && !ev_vec[B_ACK] && !ev_vec[B_HSNACK]) |=> !err_q);
  // R10
  go_value_chk: assert property (@(posedge clk) disable iff (rst)
    go_v_q |-> (go_cmd_q == GO_WORD));
endmodule

// File: rtl/i2c_evt_agg.sv
module i2c_evt_agg
  import i2c_evt_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int CNT_W    = 8,
  parameter int MIN_MSGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ev_comp,
  input  logic             ev_ackerr,
  input  logic             ev_hsnack,
  input  logic             ev_rsdone,
  input  logic             xfer_clear,
  input  logic             seq_start,
  input  logic             cfg_auto_rs,
  input  logic [CNT_W-1:0] cfg_msg_cnt,
  input  logic             cfg_fast,
  output logic             irq,
  output logic             done_pulse,
  output logic             err_flag,
  output logic             go_valid,
  output logic [REG_W-1:0] go_cmd
);
  logic [REG_W-1:0] ev_vec;

  always_comb begin
    ev_vec           = '0;
    ev_vec[B_COMP]   = ev_comp;
    ev_vec[B_ACK]    = ev_ackerr;
    ev_vec[B_HSNACK] = ev_hsnack;
    ev_vec[B_RSDONE] = ev_rsdone;
  end

  evt_status_regs #(.REG_W(REG_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .ev_vec (ev_vec),
    .we     (reg_we),
    .sel    (reg_sel),
    .wdata  (reg_wdata),
    .rdata_q(reg_rdata),
    .irq_q  (irq)
  );

  evt_tracker #(.REG_W(REG_W), .CNT_W(CNT_W), .MIN_MSGS(MIN_MSGS)) u_trk (
    .clk        (clk),
    .rst        (rst),
    .ev_vec     (ev_vec),
    .xfer_clear (xfer_clear),
    .seq_start  (seq_start),
    .cfg_auto_rs(cfg_auto_rs),
    .cfg_msg_cnt(cfg_msg_cnt),
    .cfg_fast   (cfg_fast),
    .done_q     (done_pulse),
    .err_q      (err_flag),
    .go_v_q     (go_valid),
    .go_cmd_q   (go_cmd)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq && !done_pulse && !err_flag && !go_valid));
endmodule

// File: tb/i2c_evt_agg_bench.sv
module i2c_evt_agg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 0, reg_sel = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ev_comp = 0, ev_ackerr = 0, ev_hsnack = 0, ev_rsdone = 0;
  logic        xfer_clear = 0, seq_start = 0, cfg_auto_rs = 0, cfg_fast = 0;
  logic [7:0]  cfg_msg_cnt = '0;
  logic        irq, done_pulse, err_flag, go_valid;
  logic [15:0] go_cmd;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  i2c_evt_agg u_i2c_evt_agg (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_comp(ev_comp), .ev_ackerr(ev_ackerr), .ev_hsnack(ev_hsnack),
    .ev_rsdone(ev_rsdone), .xfer_clear(xfer_clear), .seq_start(seq_start),
    .cfg_auto_rs(cfg_auto_rs), .cfg_msg_cnt(cfg_msg_cnt), .cfg_fast(cfg_fast),
    .irq(irq), .done_pulse(done_pulse), .err_flag(err_flag),
    .go_valid(go_valid), .go_cmd(go_cmd)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // e = {rsdone, hsnack, ackerr, comp}
  task automatic fire(input logic [3:0] e);
    @(negedge clk);
    {ev_rsdone, ev_hsnack, ev_ackerr, ev_comp} = e;
    @(negedge clk);
    {ev_rsdone, ev_hsnack, ev_ackerr, ev_comp} = '0;
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic new_xfer();
    @(negedge clk);
    xfer_clear = 1;
    @(negedge clk);
    xfer_clear = 0;
  endtask

  task automatic new_seq(input logic auto_rs, input logic [7:0] cnt, input logic fast);
    @(negedge clk);
    cfg_auto_rs = auto_rs; cfg_msg_cnt = cnt; cfg_fast = fast;
    seq_start = 1; xfer_clear = 1;
    @(negedge clk);
    seq_start = 0; xfer_clear = 0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq", 16'(irq), 0);
    chk("R1 done", 16'(done_pulse), 0);
    chk("R1 err", 16'(err_flag), 0);
    chk("R1 go_valid", 16'(go_valid), 0);
    chk("R1 go_cmd", go_cmd, 0);
    rd(0, v); chk("R1 status", v, 0);
    rd(1, v); chk("R1 mask", v, 0);
  endtask

  task automatic t_status();
    logic [15:0] v;
    fire(4'b0001); rd(0, v); chk("R2 comp bit0", v, 16'h0001);
    fire(4'b0010); rd(0, v); chk("R2 ack bit1", v, 16'h0003);
    fire(4'b0100); rd(0, v); chk("R2 hsnack bit2", v, 16'h0007);
    fire(4'b1000); rd(0, v); chk("R2 rsdone bit4", v, 16'h0017);
    wr(0, 16'h0005); rd(0, v); chk("R3 w1c partial", v, 16'h0012);
    wr(0, 16'h0000); rd(0, v); chk("R3 zero write keeps", v, 16'h0012);
    wr(0, 16'hFFFF); rd(0, v); chk("R3 clear all", v, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    @(negedge clk);
    ev_ackerr = 1; reg_we = 1; reg_sel = 0; reg_wdata = 16'h0002;
    @(negedge clk);
    ev_ackerr = 0; reg_we = 0;
    rd(0, v); chk("R4 event beats clear", v, 16'h0002);
    wr(0, 16'hFFFF);
  endtask

  task automatic t_mask();
    logic [15:0] v;
    wr(1, 16'hFFFF); rd(1, v); chk("R2 mask reserved zero", v, 16'h0017);
    wr(1, 16'h0004);
    fire(4'b0001); chk("R5 masked-off no irq", 16'(irq), 0);
    fire(4'b0100); chk("R5 enabled irq", 16'(irq), 1);
    wr(0, 16'h0004); chk("R5 irq drops after clear", 16'(irq), 0);
    wr(0, 16'hFFFF); wr(1, 16'h0000);
  endtask

  task automatic t_ackerr();
    new_xfer();
    fire(4'b0010);
    chk("R8 err after ack", 16'(err_flag), 1);
    chk("R6 no done on ack alone", 16'(done_pulse), 0);
    fire(4'b0001);
    chk("R6 done after comp", 16'(done_pulse), 1);
    chk("R6 err held with done", 16'(err_flag), 1);
    @(negedge clk);
    chk("R7 pulse one cycle", 16'(done_pulse), 0);
    fire(4'b0001);
    chk("R7 no second pulse", 16'(done_pulse), 0);
    new_xfer();
    chk("R11 err cleared", 16'(err_flag), 0);
    fire(4'b0001);
    chk("R11 done again after clear", 16'(done_pulse), 1);
    new_xfer();
    fire(4'b0100);
    chk("R8 hsnack err", 16'(err_flag), 1);
    new_xfer();
  endtask

  task automatic t_clear_keeps_status();
    logic [15:0] v;
    wr(0, 16'hFFFF);
    fire(4'b0010);
    new_xfer();
    rd(0, v); chk("R11 status kept", v, 16'h0002);
    @(negedge clk);
    xfer_clear = 1; ev_hsnack = 1;
    @(negedge clk);
    xfer_clear = 0; ev_hsnack = 0;
    chk("R11 same-cycle event kept", 16'(err_flag), 1);
    new_xfer(); wr(0, 16'hFFFF);
  endtask

  task automatic t_rsdone();
    new_seq(1, 1, 0);
    fire(4'b1000);
    chk("R7 rsdone with auto", 16'(done_pulse), 1);
    chk("R7 err clean", 16'(err_flag), 0);
    new_seq(0, 1, 0);
    fire(4'b1000);
    chk("R7 rsdone without auto", 16'(done_pulse), 0);
  endtask

  task automatic t_swallow();
    new_seq(1, 3, 1);
    fire(4'b0010);
    chk("R10 err before swallow", 16'(err_flag), 1);
    fire(4'b1000);
    chk("R10 go_valid", 16'(go_valid), 1);
    chk("R10 go_cmd", go_cmd, 16'hC001);
    chk("R10 no done", 16'(done_pulse), 0);
    chk("R10 sticky cleared", 16'(err_flag), 0);
    @(negedge clk);
    chk("R10 go one cycle", 16'(go_valid), 0);
    fire(4'b1000);
    chk("R10 second restart completes", 16'(done_pulse), 1);
    chk("R10 no second go", 16'(go_valid), 0);
  endtask

  task automatic t_arm_cond();
    new_seq(1, 1, 1);
    fire(4'b1000);
    chk("R9 one msg not armed", 16'(go_valid), 0);
    chk("R9 one msg completes", 16'(done_pulse), 1);
    new_seq(1, 2, 0);
    fire(4'b1000);
    chk("R9 slow not armed", 16'(go_valid), 0);
    new_seq(0, 2, 1);
    fire(4'b1000);
    chk("R9 no auto not armed", 16'(go_valid), 0);
    new_seq(1, 2, 1);
    fire(4'b1000);
    chk("R9 armed at two msgs", 16'(go_valid), 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_status();
    t_collide();
    t_mask();
    t_ackerr();
    t_clear_keeps_status();
    t_rsdone();
    t_swallow();
    t_arm_cond();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule